// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous system bus and an external asynchronous static RAM. The memory is byte wide and has one bidirectional data bus. The system side issues one request at a time: an address, a byte to write, a read/write flag and a valid strobe. The block answers with the read byte and a single-cycle completion pulse. On the memory side it drives the address, active-low chip select, write enable and output enable, the outgoing data byte, and the enable for the data-bus tristate drivers. The incoming data byte is a separate port.

All memory timings are counted in whole clock cycles. Each count comes from the nanosecond limit of the chosen speed grade, divided by the clock period given in picoseconds and rounded up, with a floor of one cycle.

A policy parameter sets what output enable does during a write:
- When it is held high, the memory never drives the bus during a write, and the write strobe can be short.
- When it is left low, the strobe is lengthened. The controller first waits for the memory's outputs to float, and only then drives the data.

When a write directly follows a read, the controller inserts an idle gap so that the memory has released the bus before the controller drives it.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and immediately after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0 and `rsp_done` is 0.
- R2: The speed grade sets the limits used for reads.
  - Speed grade 0, 1 and 2 select an access time of 20, 25 and 30 ns.
  - A read holds chip select and output enable low, with write enable high, for NA = max(1, ceil(access/period)) cycles.
  - The read data is captured at the clock edge that ends the last of these cycles.
  - `rsp_done` is high in the cycle after that edge, so it is seen NA+1 cycles after the accepting edge.
- R3: A write holds chip select and write enable low together for NW cycles.
  - With output enable held high, NW = max(ceil(14/15/17 ns), ceil(9/10/11 ns data setup)).
  - With output enable low during the write, NW = max(ceil(20/25/30 ns), ceil(5/5/6 ns float time) + ceil(9/10/11 ns)), and `mem_oe_n` stays 0 for the whole write.
- R4: `mem_dq_oe` is 1 only while chip select and write enable are both low.
  - With output enable low, it stays 0 for the first ceil(float time) cycles of the write.
  - Once driven, the data stays constant until write enable rises.
- R5: After the write strobe comes a recovery of max(1, ceil(cycle time/period) − NW) cycles with all strobes high, where the cycle time is 20/25/30 ns. `rsp_done` follows one cycle after the recovery, for a total of NW + recovery + 1 cycles.
- R6: A write whose previous request was a read first waits ceil(5/6/8 ns) cycles with all strobes high and the bus not driven, which adds that many cycles to its latency.
- R7: `mem_addr` does not change while chip select stays low between consecutive clock edges.
- R8: A `req_valid` that arrives while a request is in progress is ignored, both in the memory contents and in the number of `rsp_done` pulses.
- R9: `rsp_done` lasts exactly one cycle per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_rdata | output | DATA_W | Captured read byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
The bench builds two instances with an 8-bit address and an 8000 ps period:
- one with speed grade 0 and output enable held high during writes;
- one with speed grade 2 and output enable low during writes.

This covers both pulse-length formulas and access counts of three and four cycles. The 256-entry space allows every address to be written and read back, and each latency is compared with the cycle count computed from the nanosecond limits. A cycle-level memory model returns inverted data when sampled too early and counts short strobes, early drive, contention and address movement under chip select.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int SPEED        = 0,
  parameter int CLK_PS       = 8000,
  parameter int OE_LOW_WRITE = 0,
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int pick(input int g0, input int g1, input int g2);
    return (SPEED == 0) ? g0 : (SPEED == 1) ? g1 : g2;
  endfunction

  localparam int N_AA   = cyc(pick(20000, 25000, 30000));
  localparam int N_WC   = cyc(pick(20000, 25000, 30000));
  localparam int N_WPH  = cyc(pick(14000, 15000, 17000));
  localparam int N_WPL  = cyc(pick(20000, 25000, 30000));
  localparam int N_DW   = cyc(pick(9000, 10000, 11000));
  localparam int N_WHZ  = cyc(pick(5000, 5000, 6000));
  localparam int N_HZ   = cyc(pick(5000, 6000, 8000));
  localparam int N_WR   = OE_LOW_WRITE != 0 ? imax(N_WPL, N_WHZ + N_DW) : imax(N_WPH, N_DW);
  localparam int N_WREC = imax(1, N_WC - N_WR);
  localparam int DRV_AT = OE_LOW_WRITE != 0 ? N_WR - 1 - N_WHZ : N_WR - 1;
  localparam int N_MAX  = imax(imax(N_AA, N_WR), imax(N_WREC, N_HZ));
  localparam int CNT_W  = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_WR, S_WREC, S_RD} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             last_rd;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      last_rd   <= 1'b0;
      mem_addr  <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          wdata_q  <= req_wdata;
          if (!req_write) begin
            st  <= S_RD;
            cnt <= CNT_W'(N_AA - 1);
          end else if (last_rd) begin
            st  <= S_TURN;
            cnt <= CNT_W'(N_HZ - 1);
          end else begin
            st  <= S_WR;
            cnt <= CNT_W'(N_WR - 1);
          end
        end
        S_TURN: if (cnt == '0) begin
          st  <= S_WR;
          cnt <= CNT_W'(N_WR - 1);
        end else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          st      <= S_WREC;
          cnt     <= CNT_W'(N_WREC - 1);
          last_rd <= 1'b0;
        end else cnt <= cnt - 1'b1;
        S_WREC: if (cnt == '0) begin
          st       <= S_IDLE;
          rsp_done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        S_RD: if (cnt == '0) begin
          st        <= S_IDLE;
          rsp_rdata <= mem_dq_in;
          rsp_done  <= 1'b1;
          last_rd   <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_cs_n   = !(st == S_WR || st == S_RD);
  assign mem_we_n   = (st != S_WR);
  assign mem_oe_n   = !(st == S_RD || (OE_LOW_WRITE != 0 && st == S_WR));
  assign mem_dq_oe  = (st == S_WR) && (cnt <= CNT_W'(DRV_AT));
  assign mem_dq_out = wdata_q;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int SPEED        = 0,
  parameter int CLK_PS       = 8000,
  parameter int OE_LOW_WRITE = 0,
  parameter int ADDR_W       = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  function automatic int cyc(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int WP_PS  = OE_LOW_WRITE != 0 ?
                          ((SPEED == 0) ? 20000 : (SPEED == 1) ? 25000 : 30000) :
                          ((SPEED == 0) ? 14000 : (SPEED == 1) ? 15000 : 17000);
  localparam int WP_MIN = cyc(WP_PS);

  int we_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) we_lo <= 0;
    else if (!mem_we_n) we_lo <= we_lo + 1;
    else we_lo <= 0;
  end

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo >= WP_MIN));

  a_r4_drive_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_cs_n && !mem_we_n));

  a_r4_float_first: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && !mem_oe_n) |-> !$past(mem_we_n));

  a_r6_no_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mem_cs_n && !mem_oe_n && mem_we_n) |-> !mem_dq_oe);

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .SPEED(SPEED), .CLK_PS(CLK_PS), .OE_LOW_WRITE(OE_LOW_WRITE), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rsp_done(rsp_done), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps

module sram_model_tb #(
  parameter int N_AA  = 3,
  parameter int N_WP  = 2,
  parameter int N_DW  = 2,
  parameter int N_WHZ = 1,
  parameter int N_HZ  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic [7:0] addr,
  input  logic       dq_oe,
  input  logic [7:0] dq_out,
  output logic [7:0] dq_in,
  output int         errs
);
  logic [7:0] mem [256];
  int acc, welo, dstab, tail;
  logic [7:0] dlast, wa, prev_addr;
  logic prev_cs_n;
  wire rd = !cs_n && we_n && !oe_n;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  assign dq_in = (acc + 1 >= N_AA) ? mem[addr] : ~mem[addr];

  always @(posedge clk) begin : blk
    int e;
    e = 0;
    if (!rst_n) begin
      acc <= 0; welo <= 0; dstab <= 0; tail <= 0; errs <= 0;
      dlast <= 0; wa <= 0; prev_addr <= 0; prev_cs_n <= 1'b1;
    end else begin
      acc  <= rd ? acc + 1 : 0;
      tail <= rd ? N_HZ : (tail > 0 ? tail - 1 : 0);
      if (dq_oe && (rd || tail > 0)) begin
        e++; $display("model: bus contention with read output at %0t", $time);
      end
      if (dq_oe && !oe_n && !we_n && welo < N_WHZ) begin
        e++; $display("model: drive before output float at %0t", $time);
      end
      if (!cs_n && !we_n) begin
        welo <= welo + 1;
        wa   <= addr;
        if (dq_oe) begin
          dstab <= (dstab > 0 && dq_out == dlast) ? dstab + 1 : 1;
          dlast <= dq_out;
        end else dstab <= 0;
      end else if (welo > 0) begin
        if (welo < N_WP) begin
          e++; $display("model: write strobe %0d < %0d cycles", welo, N_WP);
        end
        if (dstab < N_DW) begin
          e++; $display("model: data setup %0d < %0d cycles", dstab, N_DW);
        end
        mem[wa] <= dlast;
        welo  <= 0;
        dstab <= 0;
      end
      if (!cs_n && !prev_cs_n && addr != prev_addr) begin
        e++; $display("model: address moved under chip select at %0t", $time);
      end
      prev_cs_n <= cs_n;
      prev_addr <= addr;
      errs <= errs + e;
    end
  end
endmodule

module test_sram_ctrl;
  localparam int PER_PS = 8000;

  function automatic int ce(input int ns);
    int c;
    c = (ns * 1000 + PER_PS - 1) / PER_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction
  function automatic int gsel(input int g, input int a, input int b, input int c);
    return g == 0 ? a : g == 1 ? b : c;
  endfunction
  function automatic int grade_of(input int k);
    return k == 0 ? 0 : 2;
  endfunction
  function automatic int n_aa(input int g);  return ce(gsel(g, 20, 25, 30)); endfunction
  function automatic int n_whz(input int g); return ce(gsel(g, 5, 5, 6)); endfunction
  function automatic int n_hz(input int g);  return ce(gsel(g, 5, 6, 8)); endfunction
  function automatic int n_dw(input int g);  return ce(gsel(g, 9, 10, 11)); endfunction
  function automatic int n_wp(input int g, input int oel);
    return oel != 0 ? ce(gsel(g, 20, 25, 30)) : ce(gsel(g, 14, 15, 17));
  endfunction
  function automatic int n_wr(input int g, input int oel);
    return oel != 0 ? mx(n_wp(g, 1), n_whz(g) + n_dw(g)) : mx(n_wp(g, 0), n_dw(g));
  endfunction
  function automatic int lat_wr(input int g, input int oel);
    return n_wr(g, oel) + mx(1, ce(gsel(g, 20, 25, 30)) - n_wr(g, oel)) + 1;
  endfunction
  function automatic logic [7:0] pat(input int k, input int a);
    return 8'((a * 37 + 11 + k * 100) & 255);
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req_valid [2];
  logic       req_write [2];
  logic [7:0] req_addr  [2];
  logic [7:0] req_wdata [2];
  logic [7:0] rdata     [2];
  logic       done      [2];
  logic [7:0] maddr     [2];
  logic       cs_n [2], we_n [2], oe_n [2], dq_oe [2];
  logic [7:0] dq_out [2], dq_in [2];
  int         merr [2];

  for (genvar k = 0; k < 2; k++) begin : g_dut
    localparam int G = (k == 0) ? 0 : 2;
    sram_ctrl #(.SPEED(G), .CLK_PS(PER_PS), .OE_LOW_WRITE(k), .ADDR_W(8), .DATA_W(8)) i_sram_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[k]), .req_write(req_write[k]), .req_addr(req_addr[k]),
      .req_wdata(req_wdata[k]), .rsp_rdata(rdata[k]), .rsp_done(done[k]),
      .mem_addr(maddr[k]), .mem_cs_n(cs_n[k]), .mem_we_n(we_n[k]), .mem_oe_n(oe_n[k]),
      .mem_dq_oe(dq_oe[k]), .mem_dq_out(dq_out[k]), .mem_dq_in(dq_in[k])
    );
    sram_model_tb #(.N_AA(n_aa(G)), .N_WP(n_wp(G, k)), .N_DW(n_dw(G)),
                    .N_WHZ(n_whz(G)), .N_HZ(n_hz(G))) i_mem (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n[k]), .we_n(we_n[k]), .oe_n(oe_n[k]),
      .addr(maddr[k]), .dq_oe(dq_oe[k]), .dq_out(dq_out[k]), .dq_in(dq_in[k]), .errs(merr[k])
    );
  end

  int nchk = 0;
  int nfail = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input int k, input bit wr, input logic [7:0] a, input logic [7:0] d,
                    output int lat, output logic [7:0] q);
    @(negedge clk);
    req_valid[k] = 1'b1; req_write[k] = wr; req_addr[k] = a; req_wdata[k] = d;
    @(negedge clk);
    req_valid[k] = 1'b0;
    lat = 1;
    while (!done[k] && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    q = rdata[k];
    @(negedge clk);
    chk(done[k] == 1'b0, "R9 done width", int'(done[k]), 0);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      req_valid[k] = 0; req_write[k] = 0; req_addr[k] = 0; req_wdata[k] = 0;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(cs_n[k] && we_n[k] && oe_n[k] && !dq_oe[k] && !done[k], "R1 reset strobes",
          {cs_n[k], we_n[k], oe_n[k], dq_oe[k], done[k]}, 5'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk(cs_n[k] && we_n[k] && oe_n[k] && !dq_oe[k] && !done[k], "R1 after reset",
          {cs_n[k], we_n[k], oe_n[k], dq_oe[k], done[k]}, 5'b11100);

    for (int k = 0; k < 2; k++) begin
      int g, lat, cnt_done;
      logic [7:0] q;
      g = grade_of(k);
      for (int a = 0; a < 256; a++) begin
        op(k, 1'b1, 8'(a), pat(k, a), lat, q);
        chk(lat == lat_wr(g, k), "R3 R5 write latency", lat, lat_wr(g, k));
      end
      for (int a = 0; a < 256; a++) begin
        op(k, 1'b0, 8'(a), 8'h00, lat, q);
        chk(q == pat(k, a), "R2 read data", q, pat(k, a));
        chk(lat == n_aa(g) + 1, "R2 read latency", lat, n_aa(g) + 1);
      end
      op(k, 1'b0, 8'd10, 8'h00, lat, q);
      op(k, 1'b1, 8'd10, 8'h5A, lat, q);
      chk(lat == lat_wr(g, k) + n_hz(g), "R6 turnaround latency", lat, lat_wr(g, k) + n_hz(g));
      op(k, 1'b0, 8'd10, 8'h00, lat, q);
      chk(q == 8'h5A, "R6 write after read data", q, 8'h5A);

      // R8: a second request while a read is in flight
      @(negedge clk);
      req_valid[k] = 1'b1; req_write[k] = 1'b0; req_addr[k] = 8'd20;
      @(negedge clk);
      req_write[k] = 1'b1; req_addr[k] = 8'd21; req_wdata[k] = ~pat(k, 21);
      @(negedge clk);
      req_valid[k] = 1'b0;
      cnt_done = 0;
      for (int i = 0; i < 20; i++) begin
        if (done[k]) cnt_done++;
        @(negedge clk);
      end
      chk(cnt_done == 1, "R8 single completion", cnt_done, 1);
      chk(rdata[k] == pat(k, 20), "R8 first request served", rdata[k], pat(k, 20));
      op(k, 1'b0, 8'd21, 8'h00, lat, q);
      chk(q == pat(k, 21), "R8 ignored write", q, pat(k, 21));

      chk(merr[k] == 0, "R4 R7 memory timing", merr[k], 0);
    end

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule